// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations so that an address can be translated without a page-table access. It holds a small set of entries. Any translation may sit in any entry. The virtual page numbers live in a content-addressable tag array. The physical page numbers live in a separate RAM array, one word per tag. A lookup compares the incoming virtual page number against every valid tag in parallel. Each tag raises its own match line, and that match line gates its RAM word onto the output. Hit is the OR of all match lines.

The lookup path is combinational from the stored state. New translations arrive through a refill port and are written at the clock edge. A refill whose page number is already cached overwrites that entry. Otherwise the refill takes the lowest-numbered empty entry. When the buffer is full, it takes the entry named by a round-robin victim pointer. A flush input empties the whole buffer in one edge.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns `lookHit`=0 and `lookPpn`=0, and the victim pointer is 0.
- R2: When a valid entry holds a page number equal to `lookVpn`, `lookHit` is 1 and `lookPpn` equals that entry's physical page number in the same cycle, with no clock edge in between.
- R3: When no valid entry matches `lookVpn`, `lookHit` is 0 and `lookPpn` is all zeros.
- R4: At most one match line is ever active, so `lookPpn` is never the OR of two different stored words.
- R5: A refill (`fillEn`=1, `flushEn`=0) whose VPN is not cached and that finds at least one invalid entry writes the lowest-indexed invalid entry. The new translation is visible from the cycle after the edge.
- R6: A refill whose VPN is not cached and that finds all entries valid overwrites the entry indexed by the victim pointer. The pointer steps by one, wrapping from 7 to 0, on every accepted refill, whichever entry the refill wrote.
- R7: A refill whose VPN is already cached replaces that entry's physical page number in place and leaves every other entry unchanged.
- R8: `flushEn` invalidates all entries at the next edge. In the same cycle it overrides a refill: the refill is dropped and the victim pointer holds its value.
- R9: A lookup in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookVpn | input | 20 | Virtual page number to translate |
| lookHit | output | 1 | A valid entry matches `lookVpn` |
| lookPpn | output | 20 | Physical page number of the matching entry, zero on miss |
| fillEn | input | 1 | Write a translation at this edge |
| fillVpn | input | 20 | Virtual page number to store |
| fillPpn | input | 20 | Physical page number to store |
| flushEn | input | 1 | Invalidate every entry at this edge |

## Verification
Lookup results depend only on `lookVpn` and the stored state, so they are due in the same cycle the page number is applied. The bench drives each input on a falling edge and samples 1 ns later, before the next rising edge. Refills and flushes pass through exactly one register stage. Their effect is therefore checked by a lookup issued on the falling edge after the rising edge that captured them. The bench also checks in the capturing cycle itself, to confirm that the old contents are still seen there. The expected contents and the victim pointer come from a reference model in the bench that applies the refill and flush rules. The bench updates that model at the same edges.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Strobes from the control to the tag and data arrays.
  typedef struct packed {
    logic wrEn;    // write the entry picked by the one-hot select
    logic clrAll;  // invalidate every entry
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_tag_cam.sv
module xlat_tag_cam
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlatStrobe_t        strobe,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic [VPN_W-1:0]   wrVpn,
  input  logic [VPN_W-1:0]   lookVpn,
  output logic [ENTRIES-1:0] lookMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] validVec
);

  logic [VPN_W-1:0] tagQ [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[e] <= 1'b0;
        tagQ[e]     <= '0;
      end else if (strobe.clrAll) begin
        validVec[e] <= 1'b0;
      end else if (strobe.wrEn && wrSel[e]) begin
        validVec[e] <= 1'b1;
        tagQ[e]     <= wrVpn;
      end
    end

    // One match line per word, qualified by its valid bit.
    assign lookMatch[e] = validVec[e] && (tagQ[e] == lookVpn);
    assign fillMatch[e] = validVec[e] && (tagQ[e] == wrVpn);
  end

  // R4: the refill rule must never leave two words holding one page number.
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch));

  // R8: a clear strobe leaves no valid word behind.
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (validVec == '0));

endmodule

// File: rtl/xlat_ppn_ram.sv
module xlat_ppn_ram
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PPN_W   = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlatStrobe_t        strobe,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic [PPN_W-1:0]   wrPpn,
  input  logic [ENTRIES-1:0] matchLn,
  output logic [PPN_W-1:0]   rdPpn
);

  logic [PPN_W-1:0] wordQ [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ[e] <= '0;
      end else if (strobe.wrEn && !strobe.clrAll && wrSel[e]) begin
        wordQ[e] <= wrPpn;
      end
    end
  end

  // Each match line gates its own word onto a wired-OR output.
  always_comb begin
    rdPpn = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      rdPpn = rdPpn | (wordQ[e] & {PPN_W{matchLn[e]}});
    end
  end

  // R3: with no match line raised, the output bus stays at zero.
  a_r3_zero_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (matchLn == '0) |-> (rdPpn == '0));

endmodule

// File: rtl/xlat_victim_ctrl.sv
module xlat_victim_ctrl
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic               flushEn,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic [ENTRIES-1:0] validVec,
  output xlatStrobe_t        strobe,
  output logic [ENTRIES-1:0] wrSel
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   victimPtr;
  logic [ENTRIES-1:0] freeSel;
  logic               anyFree;

  // Lowest-indexed invalid entry, one-hot.
  always_comb begin
    freeSel = '0;
    anyFree = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!validVec[e]) begin
        freeSel    = '0;
        freeSel[e] = 1'b1;
        anyFree    = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clrAll = flushEn;
    strobe.wrEn   = fillEn && !flushEn;
    if (|fillMatch) begin
      wrSel = fillMatch;
    end else if (anyFree) begin
      wrSel = freeSel;
    end else begin
      wrSel = '0;
      wrSel[victimPtr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (strobe.wrEn) begin
      victimPtr <= (victimPtr == LAST_IDX) ? '0 : victimPtr + 1'b1;
    end
  end

  // R5/R7: every accepted refill targets exactly one entry.
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> ($countones(wrSel) == 1));

  // R6: the pointer takes one step per accepted refill.
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flushEn) |=>
      (victimPtr == (($past(victimPtr) == LAST_IDX) ? '0 : $past(victimPtr) + 1'b1)));

  // R8: a flush freezes the pointer.
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    flushEn |=> (victimPtr == $past(victimPtr)));

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lookVpn,
  output logic             lookHit,
  output logic [PPN_W-1:0] lookPpn,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             flushEn
);

  xlatStrobe_t        strobe;
  logic [ENTRIES-1:0] wrSel;
  logic [ENTRIES-1:0] lookMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] validVec;

  xlat_victim_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .flushEn(flushEn),
    .fillMatch(fillMatch), .validVec(validVec),
    .strobe(strobe), .wrSel(wrSel)
  );

  xlat_tag_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) cam_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSel(wrSel),
    .wrVpn(fillVpn), .lookVpn(lookVpn),
    .lookMatch(lookMatch), .fillMatch(fillMatch), .validVec(validVec)
  );

  xlat_ppn_ram #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) ram_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSel(wrSel),
    .wrPpn(fillPpn), .matchLn(lookMatch), .rdPpn(lookPpn)
  );

  assign lookHit = |lookMatch;

  // R2: a hit always carries a one-hot match vector.
  a_r2_hit_single: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> $onehot(lookMatch));

endmodule

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] lookVpn = '0;
  logic        lookHit;
  logic [19:0] lookPpn;
  logic        fillEn = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPpn = '0;
  logic        flushEn = 1'b0;

  int errors = 0;
  int checks = 0;

  // Reference model
  logic [19:0] mVpn [N];
  logic [19:0] mPpn [N];
  logic        mVal [N];
  int          mPtr;

  always #2 clk = ~clk;

  xlat_tlb dut_i (
    .clk(clk), .rstN(rstN), .lookVpn(lookVpn), .lookHit(lookHit),
    .lookPpn(lookPpn), .fillEn(fillEn), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .flushEn(flushEn)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 lookup, 1 refill, 2 flush
    logic [19:0] vpn;
    logic [19:0] ppn;
  } vec_t;

  localparam vec_t VECS [21] = '{
    '{2'd1, 20'h11111, 20'hAAAAA},
    '{2'd0, 20'h11111, 20'h00000},
    '{2'd0, 20'h22222, 20'h00000},
    '{2'd1, 20'h22222, 20'hBBBBB},
    '{2'd1, 20'h11111, 20'hCCCCC},   // overwrite in place (R7)
    '{2'd0, 20'h11111, 20'h00000},
    '{2'd0, 20'h22222, 20'h00000},
    '{2'd1, 20'h33333, 20'h03333},
    '{2'd1, 20'h44444, 20'h04444},
    '{2'd1, 20'h55555, 20'h05555},
    '{2'd1, 20'h66666, 20'h06666},
    '{2'd1, 20'h77777, 20'h07777},
    '{2'd1, 20'h88888, 20'h08888},
    '{2'd1, 20'h99999, 20'h09999},   // full: evicts pointer entry (R6)
    '{2'd0, 20'h22222, 20'h00000},
    '{2'd0, 20'h99999, 20'h00000},
    '{2'd0, 20'h11111, 20'h00000},
    '{2'd0, 20'h88888, 20'h00000},
    '{2'd2, 20'h00000, 20'h00000},
    '{2'd0, 20'h99999, 20'h00000},
    '{2'd0, 20'h33333, 20'h00000}
  };

  function automatic void modelFill(logic [19:0] v, logic [19:0] p);
    int tgt = -1;
    for (int e = 0; e < N; e++) if (tgt < 0 && mVal[e] && mVpn[e] == v) tgt = e;
    for (int e = 0; e < N; e++) if (tgt < 0 && !mVal[e]) tgt = e;
    if (tgt < 0) tgt = mPtr;
    mVal[tgt] = 1'b1;
    mVpn[tgt] = v;
    mPpn[tgt] = p;
    mPtr = (mPtr + 1) % N;
  endfunction

  function automatic void modelFlush();
    for (int e = 0; e < N; e++) mVal[e] = 1'b0;
  endfunction

  task automatic checkLook(input logic [19:0] v, input string req);
    logic        eHit = 1'b0;
    logic [19:0] ePpn = '0;
    lookVpn = v;
    #1;
    for (int e = 0; e < N; e++) if (mVal[e] && mVpn[e] == v) begin
      eHit = 1'b1;
      ePpn = mPpn[e];
    end
    checks++;
    if (lookHit !== eHit || lookPpn !== ePpn) begin
      errors++;
      $display("FAIL %s vpn=%h: hit=%b ppn=%h expected hit=%b ppn=%h",
               req, v, lookHit, lookPpn, eHit, ePpn);
    end
  endtask

  task automatic doFill(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    fillEn = 1'b1; fillVpn = v; fillPpn = p;
    @(negedge clk);
    fillEn = 1'b0;
    modelFill(v, p);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flushEn = 1'b1;
    @(negedge clk);
    flushEn = 1'b0;
    modelFlush();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int e = 0; e < N; e++) begin
      mVal[e] = 1'b0; mVpn[e] = '0; mPpn[e] = '0;
    end
    mPtr = 0;

    // R1: during and after reset, nothing hits.
    #1;
    checkLook(20'h00000, "R1");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkLook(20'h00000, "R1");
    checkLook(20'h12345, "R1");

    // Table walk: R2 hits, R3 misses, R7 overwrite, R6 eviction.
    for (int i = 0; i < 21; i++) begin
      case (VECS[i].op)
        2'd1: doFill(VECS[i].vpn, VECS[i].ppn);
        2'd2: doFlush();
        default: begin
          @(negedge clk);
          checkLook(VECS[i].vpn, (i == 5) ? "R7" : (i == 14) ? "R6" : "R2/R3");
        end
      endcase
    end

    // R4: overwrite with disjoint bits must not OR two words.
    doFill(20'hABCDE, 20'hF0F0F);
    doFill(20'hABCDE, 20'h0F0F0);
    @(negedge clk);
    checkLook(20'hABCDE, "R4");

    // R9: lookup in the refill cycle sees old contents.
    @(negedge clk);
    fillEn = 1'b1; fillVpn = 20'h5A5A5; fillPpn = 20'h12121;
    checkLook(20'h5A5A5, "R9");
    @(negedge clk);
    fillEn = 1'b0;
    modelFill(20'h5A5A5, 20'h12121);
    checkLook(20'h5A5A5, "R9");

    // R8: flush with a simultaneous refill drops the refill.
    @(negedge clk);
    flushEn = 1'b1; fillEn = 1'b1; fillVpn = 20'h77700; fillPpn = 20'h00777;
    @(negedge clk);
    flushEn = 1'b0; fillEn = 1'b0;
    modelFlush();
    checkLook(20'h77700, "R8");
    checkLook(20'h5A5A5, "R8");

    // R5 then R6: fill an empty buffer, then one more evicts the pointer entry.
    for (int k = 0; k < N; k++) doFill(20'hC0000 + 20'(k), 20'hD0000 + 20'(k));
    @(negedge clk);
    for (int k = 0; k < N; k++) checkLook(20'hC0000 + 20'(k), "R5");
    doFill(20'hEEEEE, 20'h0EEEE);
    @(negedge clk);
    checkLook(20'hEEEEE, "R6");
    for (int k = 0; k < N; k++) checkLook(20'hC0000 + 20'(k), "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule